// File: doc/BRIEF.md
# Configurable Bidirectional Port Register Bank

This block keeps the state of one general-purpose parallel port of configurable width (eight pins by default). It holds a direction register, an output latch and a per-bit read-inversion mask. From these it produces a per-pin drive enable and a drive value for the pad cells. It also samples the pin levels through a multi-flop synchroniser and returns a read byte chosen by a two-bit pointer.

A serial bus controller sits in front of the block. It decodes the transaction, presents the pointer and the assembled data byte, and pulses a one-cycle write strobe once the byte is complete. For a read, it pulses a one-cycle capture strobe at the acknowledge clock edge, and the selected value is frozen into the read byte at that edge. The pad drivers and the bus protocol are outside this block.

Top module: `portreg_bank`

## Requirements
- R1: After reset the output latch is all ones, the inversion mask is all zeros and the direction register is all ones. Therefore `pin_oe` is all zeros, `pin_out` is all zeros and `rd_data` is zero.
- R2: The pointer encoding is 0 = pin levels, 1 = output latch, 2 = inversion mask, 3 = direction. A write (`wr_en` high) changes the selected register at that clock edge, so its effect appears on the outputs one cycle after the strobe.
- R3: A direction bit of 1 makes that pin an input (`pin_oe` bit 0, driver released). A direction bit of 0 makes it an output (`pin_oe` bit 1).
- R4: `pin_out` carries the output latch bit on pins whose `pin_oe` is 1 and 0 on every other pin.
- R5: A write with pointer 0 changes no register: `pin_oe`, `pin_out` and the values read back from pointers 1, 2 and 3 stay as they were.
- R6: A read with pointer 0 returns the synchronised pin levels XOR the inversion mask, for every pin whatever its direction.
- R7: A read with pointer 1 returns the stored latch value, including bits of pins that are inputs, and never the pin levels.
- R8: A read with pointer 2 or 3 returns the value last written to that register.
- R9: `rd_data` is loaded only at an edge where `capture` is high, and holds its value at every other edge.
- R10: The pins pass through a two-flop synchroniser. A pin change made between edges k-1 and k is seen by a capture at edge k+2, and is not yet seen by a capture at edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | One-cycle write strobe from the bus controller |
| ptr | input | 2 | Register pointer |
| wr_data | input | WIDTH | Data byte to write |
| capture | input | 1 | One-cycle strobe that loads the read byte |
| rd_data | output | WIDTH | Read byte |
| pin_in | input | WIDTH | Asynchronous pin levels from the pads |
| pin_out | output | WIDTH | Drive value to the pads |
| pin_oe | output | WIDTH | Per-pin drive enable, 1 = drive |

## Verification
The bench drives inputs on the falling clock edge and samples on the next falling edge. Register writes and captured reads are each due one rising edge after their strobe, and the bench checks them half a period after that edge. A pin change needs two more rising edges to pass the synchroniser. The bench therefore holds the pins for two edges before an input capture. It also makes one deliberate capture a single edge after a pin change and expects the old value there.

// File: rtl/portreg_pkg.sv
package portreg_pkg;
    typedef enum logic [1:0] {
        SEL_PINS = 2'd0,
        SEL_LAT  = 2'd1,
        SEL_INV  = 2'd2,
        SEL_DIR  = 2'd3
    } sel_e;
endpackage

// File: rtl/portreg_sync.sv
module portreg_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_chain
        always_comb begin
            stage_d[s] = stage_q[s-1];
        end
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_regs
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_d[s];
        end
    end

    assign sync_out = stage_q[STAGES-1];

    // R10: the last stage follows the one before it by exactly one edge
    if (STAGES > 1) begin : g_chk
        p_sync_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> stage_q[STAGES-1] == $past(stage_q[STAGES-2]));
    end
endmodule

// File: rtl/portreg_regs.sv
module portreg_regs
    import portreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       ptr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] lat_val,
    output logic [WIDTH-1:0] inv_val,
    output logic [WIDTH-1:0] dir_val
);
    typedef struct packed {
        logic [WIDTH-1:0] lat;
        logic [WIDTH-1:0] inv;
        logic [WIDTH-1:0] dir;
    } regs_t;

    localparam regs_t RESET_VAL = '{lat: '1, inv: '0, dir: '1};

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (sel_e'(ptr))
                SEL_LAT:  r_d.lat = wr_data;
                SEL_INV:  r_d.inv = wr_data;
                SEL_DIR:  r_d.dir = wr_data;
                default:  r_d     = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RESET_VAL;
        else        r_q <= r_d;
    end

    assign lat_val = r_q.lat;
    assign inv_val = r_q.inv;
    assign dir_val = r_q.dir;

    // R5: a write aimed at the pin-level pointer leaves all state alone
    p_pins_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == 2'd0) |=> $stable(r_q));
    // R2: without a strobe nothing changes
    p_no_strobe_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(r_q));
endmodule

// File: rtl/portreg_readback.sv
module portreg_readback
    import portreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [1:0]       ptr,
    input  logic [WIDTH-1:0] pins_sync,
    input  logic [WIDTH-1:0] lat_val,
    input  logic [WIDTH-1:0] inv_val,
    input  logic [WIDTH-1:0] dir_val,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] sel_val;
    logic [WIDTH-1:0] rd_d, rd_q;

    always_comb begin
        unique case (sel_e'(ptr))
            SEL_PINS: sel_val = pins_sync ^ inv_val;
            SEL_LAT:  sel_val = lat_val;
            SEL_INV:  sel_val = inv_val;
            default:  sel_val = dir_val;
        endcase
        rd_d = capture ? sel_val : rd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

    // R9: the read byte is frozen between captures
    p_hold_no_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(rd_q));
    // R7: a latch read returns the stored latch, not the pins
    p_latch_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && ptr == 2'd1) |=> rd_q == $past(lat_val));
    // R6: a pin read applies the inversion mask
    p_pin_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && ptr == 2'd0) |=> rd_q == ($past(pins_sync) ^ $past(inv_val)));
endmodule

// File: rtl/portreg_bank.sv
module portreg_bank #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       ptr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             capture,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    logic [WIDTH-1:0] pins_sync;
    logic [WIDTH-1:0] lat_val, inv_val, dir_val;

    portreg_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pins_sync)
    );

    portreg_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data),
        .lat_val(lat_val), .inv_val(inv_val), .dir_val(dir_val)
    );

    portreg_readback #(.WIDTH(WIDTH)) u_rd (
        .clk(clk), .rst_n(rst_n), .capture(capture), .ptr(ptr),
        .pins_sync(pins_sync), .lat_val(lat_val), .inv_val(inv_val),
        .dir_val(dir_val), .rd_data(rd_data)
    );

    assign pin_oe  = ~dir_val;
    assign pin_out = lat_val & ~dir_val;

    // R4: no value is presented on a pin whose driver is released
    p_no_drive_when_released_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0);
    // R3: a direction write sets the drive enables to its complement
    p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == 2'd3) |=> pin_oe == ~$past(wr_data));
    // R5: pointer-0 writes leave the pad outputs alone
    p_pad_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == 2'd0) |=> ($stable(pin_oe) && $stable(pin_out)));
endmodule

// File: tb/sim_portreg_bank.sv
module sim_portreg_bank;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   ptr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic         capture = 1'b0;
    logic [W-1:0] rd_data;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out;
    logic [W-1:0] pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    portreg_bank #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data),
        .capture(capture), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] p, input logic [W-1:0] d);
        wr_en = 1'b1; ptr = p; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] p);
        capture = 1'b1; ptr = p;
        @(negedge clk);
        capture = 1'b0;
    endtask

    task automatic set_pins(input logic [W-1:0] v);
        pin_in = v;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 oe", pin_oe, 8'h00);
        check("R1 out", pin_out, 8'h00);
        check("R1 rd", rd_data, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd1); check("R1 latch", rd_data, 8'hFF);
        rd(2'd2); check("R1 inv", rd_data, 8'h00);
        rd(2'd3); check("R1 dir", rd_data, 8'hFF);

        // R3 R4: sweep latch x direction patterns
        for (int d = 0; d < 256; d += 17) begin
            for (int l = 0; l < 256; l += 23) begin
                wr(2'd1, 8'(l));
                wr(2'd3, 8'(d));
                check("R3 oe", pin_oe, ~8'(d));
                check("R4 out", pin_out, 8'(l) & ~8'(d));
            end
        end

        // R8: readback of inversion and direction, R7 latch readback
        for (int v = 0; v < 256; v += 29) begin
            wr(2'd2, 8'(v));
            wr(2'd3, 8'(v ^ 8'h5A));
            wr(2'd1, 8'(v ^ 8'hC3));
            pin_in = ~8'(v ^ 8'hC3);
            rd(2'd2); check("R8 inv", rd_data, 8'(v));
            rd(2'd3); check("R8 dir", rd_data, 8'(v ^ 8'h5A));
            rd(2'd1); check("R7 latch", rd_data, 8'(v ^ 8'hC3));
        end

        // R6: exhaustive inversion mask, pins independent of direction
        wr(2'd3, 8'h0F);
        for (int m = 0; m < 256; m++) begin
            wr(2'd2, 8'(m));
            set_pins(8'(m * 37 + 11));
            rd(2'd0);
            check("R6 pins", rd_data, 8'(m * 37 + 11) ^ 8'(m));
        end

        // R5: pointer-0 write leaves everything
        wr(2'd1, 8'hA5); wr(2'd2, 8'h3C); wr(2'd3, 8'h81);
        wr(2'd0, 8'h00);
        check("R5 oe", pin_oe, 8'h7E);
        check("R5 out", pin_out, 8'h24);
        wr(2'd0, 8'hFF);
        rd(2'd1); check("R5 latch", rd_data, 8'hA5);
        rd(2'd2); check("R5 inv", rd_data, 8'h3C);
        rd(2'd3); check("R5 dir", rd_data, 8'h81);

        // R9: no capture -> hold while pointer and pins move
        held = rd_data;
        wr(2'd2, 8'h00);
        pin_in = 8'h66; ptr = 2'd0;
        repeat (4) @(negedge clk);
        check("R9 hold", rd_data, held);
        ptr = 2'd1; @(negedge clk);
        check("R9 hold ptr", rd_data, held);

        // R10: synchroniser latency
        set_pins(8'h11);
        rd(2'd0); check("R10 base", rd_data, 8'h11);
        pin_in = 8'hEE;              // changes before edge k
        @(negedge clk);              // edge k passes
        rd(2'd0);                    // capture at edge k+1
        check("R10 early", rd_data, 8'h11);
        rd(2'd0);                    // capture at edge k+2
        check("R10 late", rd_data, 8'hEE);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule